// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host with a narrow bus access to a much larger internal address space. The host bus has a 3-bit direct address, a 16-bit data path, and separate read and write strobes. Two 16-bit staging words are written first. Together they form one 32-bit write value. A 16-bit target address is then written to one of two trigger ports. Writing to the write trigger copies the staged value into the addressed target word. Writing to the read trigger fetches the addressed word into a 32-bit read staging register. The host then reads that register back as two 16-bit halves.

Each transfer fired by a trigger port opens a fixed settle window of `SETTLE` cycles (default 4). The bridge ignores every host access made during that window and records it in a sticky error flag. Internal strobes last exactly one clock. The target address and data are stable in that clock.

The internal targets are modelled behind a generic target port:
- Each of four channels has a 32-bit register bank and a 32-bit RAM. The top hex digit of the target address selects the channel.
- A 16-bit global register bank occupies F800h–F83Fh.

Top module: `ixs_bridge`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy`, `access_err`, `tgt_wstb` and `tgt_rstb` are 0, `tgt_wdata` is 0, and host reads of ports 0 and 1 return 0.
- R2: A host write to direct port 0 loads bits 15:0 of the write staging value, and port 1 loads bits 31:16. The staging value is driven on `tgt_wdata` and keeps its value across transfers.
- R3: A host write to port 2 while idle raises `tgt_wstb` for exactly one cycle, in the cycle after the write. In that cycle `tgt_addr` equals the written data and `tgt_wdata` holds the staged value.
- R4: A host write to port 3 while idle raises `tgt_rstb` for exactly one cycle, in the cycle after the write. In that cycle `tgt_addr` equals the written data.
- R5: `busy` is high for exactly `SETTLE` (4) consecutive cycles, starting in the cycle after an accepted write to port 2 or 3.
- R6: Any host read or write made while `busy` is high has no effect, and `host_rdata` is 0 during it. `access_err` goes to 1 and stays set until reset.
- R7: Once `busy` drops after a port 3 read, host reads of port 0 return bits 15:0 of the fetched word and port 1 returns bits 31:16. These values stay until the next indirect read, even if the write staging value changes.
- R8: Channel register address: bits 15:12 give channel 0..3, bits 11:8 are 0, and offsets 00h..1Fh each hold an independent 32-bit word.
- R9: Channel RAM address: bits 15:12 give the channel, bits 11:8 are 1, and offsets 00h..3Fh each hold a 32-bit word that is separate from the channel registers.
- R10: Global addresses F800h..F83Fh are 16-bit registers. Only bits 15:0 of the staged value are stored, and a read returns 0 in bits 31:16.
- R11: An address outside R8–R10 (for example F840h, 4005h or 0020h) is not written, and a read of it returns 0.
- R12: A host read of ports 2 to 7 returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Direct port select |
| host_wdata | input | 16 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Host read data, combinational |
| busy | output | 1 | Settle window in progress |
| access_err | output | 1 | Sticky: access attempted while busy |
| tgt_wstb | output | 1 | Internal write strobe |
| tgt_rstb | output | 1 | Internal read strobe |
| tgt_addr | output | 16 | Latched target address |
| tgt_wdata | output | 32 | Write staging value |

## Verification
A wrong settle counter shows up at `busy` within five cycles of a trigger write. It also shows up when the following host access is either wrongly accepted or wrongly flagged in `access_err`. A decode fault lands data in the wrong word. That only becomes visible at the next indirect read-back of either the intended address or the one that was hit by mistake. For this reason the sequence reads back unmapped, neighbouring and cross-channel addresses as well as the ones it wrote. Staging-register corruption is visible on `tgt_wdata` in the very next cycle. Read-staging corruption is visible at the next host read of port 0 or 1.

// File: rtl/ixs_pkg.sv
package ixs_pkg;

    localparam int HOST_AW   = 3;
    localparam int HOST_DW   = 16;
    localparam int TGT_AW    = 16;
    localparam int TGT_DW    = 32;
    localparam int IDX_W     = 6;
    localparam logic [5:0] GLB_PAGE = 6'b100000;

    typedef enum logic [2:0] {
        PORT_WLO  = 3'd0,
        PORT_WHI  = 3'd1,
        PORT_WADR = 3'd2,
        PORT_RADR = 3'd3
    } port_e;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_CHREG = 2'd1,
        RGN_CHRAM = 2'd2,
        RGN_GLB   = 2'd3
    } region_e;

    typedef struct packed {
        logic                wr;
        logic                rd;
        logic [TGT_AW-1:0]   addr;
        logic [TGT_DW-1:0]   data;
    } tgt_req_t;

    typedef struct packed {
        region_e             rgn;
        logic [3:0]          ch;
        logic [IDX_W-1:0]    idx;
    } tgt_loc_t;

    // Map a 16-bit target address onto a region, channel and word index.
    function automatic tgt_loc_t decode_addr(
        input logic [TGT_AW-1:0] a,
        input int                nch,
        input int                nreg,
        input int                nram,
        input int                nglb
    );
        tgt_loc_t loc;
        loc.rgn = RGN_NONE;
        loc.ch  = a[15:12];
        loc.idx = a[IDX_W-1:0];
        if (a[15:12] == 4'hF && a[11:6] == GLB_PAGE && int'(a[5:0]) < nglb) begin
            loc.rgn = RGN_GLB;
        end else if (int'(a[15:12]) < nch) begin
            if (a[11:8] == 4'h0 && int'(a[7:0]) < nreg) begin
                loc.rgn = RGN_CHREG;
            end else if (a[11:8] == 4'h1 && int'(a[7:0]) < nram) begin
                loc.rgn = RGN_CHRAM;
            end
        end
        return loc;
    endfunction

endpackage

// File: rtl/ixs_host_front.sv
module ixs_host_front
    import ixs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [HOST_DW-1:0]  host_wdata,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic                busy,
    input  logic                rd_valid,
    input  logic [TGT_DW-1:0]   rd_data,
    output tgt_req_t            req,
    output logic [HOST_DW-1:0]  host_rdata,
    output logic                start,
    output logic                viol
);

    logic [TGT_DW-1:0] whold;
    logic [TGT_DW-1:0] rhold;
    logic              wr_ok;
    logic              fire_w;
    logic              fire_r;
    logic              stb_w_q;
    logic              stb_r_q;
    logic [TGT_AW-1:0] addr_q;

    assign wr_ok  = host_wr && !busy;
    assign fire_w = wr_ok && (host_addr == PORT_WADR);
    assign fire_r = wr_ok && (host_addr == PORT_RADR);
    assign start  = fire_w || fire_r;
    assign viol   = busy && (host_wr || host_rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            whold   <= '0;
            rhold   <= '0;
            stb_w_q <= 1'b0;
            stb_r_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            stb_w_q <= fire_w;
            stb_r_q <= fire_r;
            if (start) begin
                addr_q <= host_wdata;
            end
            if (wr_ok && host_addr == PORT_WLO) begin
                whold[15:0] <= host_wdata;
            end
            if (wr_ok && host_addr == PORT_WHI) begin
                whold[31:16] <= host_wdata;
            end
            if (rd_valid) begin
                rhold <= rd_data;
            end
        end
    end

    always_comb begin
        req.wr   = stb_w_q;
        req.rd   = stb_r_q;
        req.addr = addr_q;
        req.data = whold;
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd && !busy) begin
            case (host_addr)
                PORT_WLO: host_rdata = rhold[15:0];
                PORT_WHI: host_rdata = rhold[31:16];
                default:  host_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ixs_settle.sv
module ixs_settle #(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic viol,
    output logic busy,
    output logic err
);

    localparam int CW = $clog2(SETTLE + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            err <= 1'b0;
        end else begin
            if (start) begin
                cnt <= CW'(SETTLE);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (viol) begin
                err <= 1'b1;
            end
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/ixs_target.sv
module ixs_target
    import ixs_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int CH_REGS  = 32,
    parameter int CH_WORDS = 64,
    parameter int GLB_REGS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  tgt_req_t          req,
    output logic              rd_valid,
    output logic [TGT_DW-1:0] rd_data
);

    localparam int RIW = (CH_REGS  > 1) ? $clog2(CH_REGS)  : 1;
    localparam int MIW = (CH_WORDS > 1) ? $clog2(CH_WORDS) : 1;
    localparam int GIW = (GLB_REGS > 1) ? $clog2(GLB_REGS) : 1;
    localparam int CHW = (NUM_CH   > 1) ? $clog2(NUM_CH)   : 1;

    tgt_loc_t          loc;
    logic [TGT_DW-1:0] ch_rd [NUM_CH];
    logic [15:0]       glb   [GLB_REGS];
    logic [TGT_DW-1:0] rd_next;

    assign loc = decode_addr(req.addr, NUM_CH, CH_REGS, CH_WORDS, GLB_REGS);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [TGT_DW-1:0] regs [CH_REGS];
        logic [TGT_DW-1:0] ram  [CH_WORDS];
        logic              hit;

        assign hit = (loc.ch == 4'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < CH_REGS; i++) begin
                    regs[i] <= '0;
                end
            end else if (req.wr && hit && loc.rgn == RGN_CHREG) begin
                regs[loc.idx[RIW-1:0]] <= req.data;
            end
        end

        always_ff @(posedge clk) begin
            if (req.wr && hit && loc.rgn == RGN_CHRAM) begin
                ram[loc.idx[MIW-1:0]] <= req.data;
            end
        end

        assign ch_rd[c] = (loc.rgn == RGN_CHRAM) ? ram[loc.idx[MIW-1:0]]
                                                 : regs[loc.idx[RIW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < GLB_REGS; i++) begin
                glb[i] <= '0;
            end
        end else if (req.wr && loc.rgn == RGN_GLB) begin
            glb[loc.idx[GIW-1:0]] <= req.data[15:0];
        end
    end

    always_comb begin
        case (loc.rgn)
            RGN_CHREG, RGN_CHRAM: rd_next = ch_rd[loc.ch[CHW-1:0]];
            RGN_GLB:              rd_next = {16'h0000, glb[loc.idx[GIW-1:0]]};
            default:              rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req.rd;
            if (req.rd) begin
                rd_data <= rd_next;
            end
        end
    end

endmodule

// File: rtl/ixs_bridge.sv
module ixs_bridge
    import ixs_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int CH_REGS  = 32,
    parameter int CH_WORDS = 64,
    parameter int GLB_REGS = 64,
    parameter int SETTLE   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [HOST_DW-1:0]  host_wdata,
    input  logic                host_wr,
    input  logic                host_rd,
    output logic [HOST_DW-1:0]  host_rdata,
    output logic                busy,
    output logic                access_err,
    output logic                tgt_wstb,
    output logic                tgt_rstb,
    output logic [TGT_AW-1:0]   tgt_addr,
    output logic [TGT_DW-1:0]   tgt_wdata
);

    tgt_req_t          req;
    logic              start;
    logic              viol;
    logic              rd_valid;
    logic [TGT_DW-1:0] rd_data;

    ixs_host_front u_front (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .busy       (busy),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .req        (req),
        .host_rdata (host_rdata),
        .start      (start),
        .viol       (viol)
    );

    ixs_settle #(.SETTLE(SETTLE)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .viol  (viol),
        .busy  (busy),
        .err   (access_err)
    );

    ixs_target #(
        .NUM_CH   (NUM_CH),
        .CH_REGS  (CH_REGS),
        .CH_WORDS (CH_WORDS),
        .GLB_REGS (GLB_REGS)
    ) u_target (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign tgt_wstb  = req.wr;
    assign tgt_rstb  = req.rd;
    assign tgt_addr  = req.addr;
    assign tgt_wdata = req.data;

endmodule

// File: rtl/ixs_bridge_chk.sv
module ixs_bridge_chk #(
    parameter int SETTLE = 4
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  host_addr,
    input logic [15:0] host_wdata,
    input logic        host_wr,
    input logic        host_rd,
    input logic [15:0] host_rdata,
    input logic        busy,
    input logic        access_err,
    input logic        tgt_wstb,
    input logic        tgt_rstb,
    input logic [15:0] tgt_addr,
    input logic [31:0] tgt_wdata
);

    logic [7:0] run;

    always_ff @(posedge clk) begin
        if (rst) run <= '0;
        else if (busy) run <= run + 8'd1;
        else run <= '0;
    end

    AST_WSTB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) tgt_wstb |=> !tgt_wstb); // R3
    AST_WSTB_CAUSE: assert property (@(posedge clk) disable iff (rst)
        tgt_wstb |-> $past(host_wr && host_addr == 3'd2 && !busy)); // R3
    AST_WSTB_ADDR: assert property (@(posedge clk) disable iff (rst)
        tgt_wstb |-> tgt_addr == $past(host_wdata)); // R3
    AST_WDATA_STEADY: assert property (@(posedge clk) disable iff (rst)
        tgt_wstb |-> $stable(tgt_wdata)); // R3
    AST_RSTB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) tgt_rstb |=> !tgt_rstb); // R4
    AST_RSTB_CAUSE: assert property (@(posedge clk) disable iff (rst)
        tgt_rstb |-> $past(host_wr && host_addr == 3'd3 && !busy)); // R4
    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(tgt_wstb && tgt_rstb)); // R4
    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (tgt_wstb || tgt_rstb)); // R5
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> run < 8'(SETTLE)); // R5
    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run == 8'(SETTLE)); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) access_err |=> access_err); // R6
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(access_err) |-> $past(busy && (host_wr || host_rd))); // R6
    AST_RDATA_QUIET_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> host_rdata == 16'h0000); // R6
    AST_RDATA_HIGH_PORTS: assert property (@(posedge clk) disable iff (rst)
        (host_addr[2:1] != 2'b00) |-> host_rdata == 16'h0000); // R12

endmodule

bind ixs_bridge ixs_bridge_chk #(.SETTLE(SETTLE)) u_chk (.*);

// File: tb/test_ixs_bridge.sv
`timescale 1ns/1ps
module test_ixs_bridge;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  host_addr;
    logic [15:0] host_wdata;
    logic        host_wr;
    logic        host_rd;
    logic [15:0] host_rdata;
    logic        busy;
    logic        access_err;
    logic        tgt_wstb;
    logic        tgt_rstb;
    logic [15:0] tgt_addr;
    logic [31:0] tgt_wdata;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    ixs_bridge i_ixs_bridge (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // monitor: pops expected host read data from the scoreboard
    always @(negedge clk) begin
        if (host_rd === 1'b1) begin
            if (sb.size() == 0) begin
                chk(1'b0, "scoreboard underflow", 32'(host_rdata), 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(host_rdata === e.exp, e.tag, 32'(host_rdata), 32'(e.exp));
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        @(posedge clk); #1;
        host_addr = a; host_rd = 1'b1;
        sb.push_back('{exp: exp, tag: tag});
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    // Checks the settle window of R5 after a trigger write
    task automatic settle_check(input string tag);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(busy === 1'b1 && tgt_wstb === 1'b0 && tgt_rstb === 1'b0,
                {tag, " R5 busy window"}, {29'h0, busy, tgt_wstb, tgt_rstb}, 32'h4);
        end
        @(negedge clk);
        chk(busy === 1'b0, {tag, " R5 busy released"}, 32'(busy), 32'h0);
    endtask

    task automatic ind_wr(input logic [15:0] ta, input logic [31:0] d, input string tag);
        wr(3'd0, d[15:0]);
        wr(3'd1, d[31:16]);
        @(negedge clk);
        chk(tgt_wdata === d, {tag, " R2 staging"}, tgt_wdata, d);
        wr(3'd2, ta);
        @(negedge clk);
        chk(tgt_wstb === 1'b1 && tgt_addr === ta && tgt_wdata === d && busy === 1'b1,
            {tag, " R3 write strobe"}, {tgt_wstb, busy, 14'h0, tgt_addr}, {2'b11, 14'h0, ta});
        settle_check(tag);
    endtask

    task automatic ind_rd(input logic [15:0] ta, input logic [31:0] exp, input string tag);
        wr(3'd3, ta);
        @(negedge clk);
        chk(tgt_rstb === 1'b1 && tgt_wstb === 1'b0 && tgt_addr === ta && busy === 1'b1,
            {tag, " R4 read strobe"}, {tgt_rstb, busy, 14'h0, tgt_addr}, {2'b11, 14'h0, ta});
        settle_check(tag);
        rd(3'd0, exp[15:0],  {tag, " R7 low half"});
        rd(3'd1, exp[31:16], {tag, " R7 high half"});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; host_addr = '0; host_wdata = '0; host_wr = 1'b0; host_rd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy === 1'b0 && access_err === 1'b0 && tgt_wstb === 1'b0 && tgt_rstb === 1'b0,
            "R1 flags in reset", {28'h0, busy, access_err, tgt_wstb, tgt_rstb}, 32'h0);
        chk(tgt_wdata === 32'h0, "R1 staging cleared", tgt_wdata, 32'h0);
        @(posedge clk); #1; rst = 1'b0;
        rd(3'd0, 16'h0000, "R1 read hold low");
        rd(3'd1, 16'h0000, "R1 read hold high");

        // R8 channel registers
        ind_wr(16'h2005, 32'hDEADBEEF, "R8 ch2 reg5");
        ind_rd(16'h2005, 32'hDEADBEEF, "R8 ch2 reg5");
        ind_wr(16'h001F, 32'h01234567, "R8 ch0 reg1F");
        ind_wr(16'h301F, 32'h89ABCDEF, "R8 ch3 reg1F");
        ind_rd(16'h001F, 32'h01234567, "R8 ch0 reg1F");
        ind_rd(16'h301F, 32'h89ABCDEF, "R8 ch3 reg1F");

        // R9 channel RAM
        ind_wr(16'h1100, 32'hCAFE0001, "R9 ch1 ram0");
        ind_wr(16'h113F, 32'hCAFE003F, "R9 ch1 ram3F");
        ind_rd(16'h1100, 32'hCAFE0001, "R9 ch1 ram0");
        ind_rd(16'h113F, 32'hCAFE003F, "R9 ch1 ram3F");
        ind_rd(16'h1000, 32'h00000000, "R9 ch1 reg0 untouched");

        // R10 global 16-bit registers
        ind_wr(16'hF810, 32'h1234ABCD, "R10 glb10");
        ind_rd(16'hF810, 32'h0000ABCD, "R10 glb10");
        ind_wr(16'hF83F, 32'hFFFF5A5A, "R10 glb3F");
        ind_rd(16'hF83F, 32'h00005A5A, "R10 glb3F");

        // R11 unmapped
        ind_wr(16'hF840, 32'h5555AAAA, "R11 F840");
        ind_rd(16'hF840, 32'h00000000, "R11 F840");
        ind_wr(16'h4005, 32'h77778888, "R11 ch4");
        ind_rd(16'h4005, 32'h00000000, "R11 ch4");
        ind_rd(16'h0005, 32'h00000000, "R11 ch0 reg5 not aliased");
        ind_wr(16'h0020, 32'h11112222, "R11 reg beyond bank");
        ind_rd(16'h0020, 32'h00000000, "R11 reg beyond bank");
        ind_rd(16'hF800, 32'h00000000, "R11 glb0 not aliased");

        // R7 read staging persists while write staging changes; R12 high ports
        ind_rd(16'h2005, 32'hDEADBEEF, "R7 reload");
        wr(3'd0, 16'h0BAD);
        wr(3'd1, 16'hF00D);
        rd(3'd0, 16'hBEEF, "R7 hold after staging write");
        rd(3'd1, 16'hDEAD, "R7 hold after staging write");
        rd(3'd2, 16'h0000, "R12 port2 read");
        rd(3'd3, 16'h0000, "R12 port3 read");
        rd(3'd5, 16'h0000, "R12 port5 read");
        rd(3'd0, 16'hBEEF, "R12 state unchanged");

        // R2 staging value reused without reload
        wr(3'd2, 16'h2007);
        @(negedge clk);
        chk(tgt_wstb === 1'b1 && tgt_wdata === 32'hF00D0BAD, "R2 reuse strobe", tgt_wdata, 32'hF00D0BAD);
        settle_check("R2 reuse");
        ind_rd(16'h2007, 32'hF00D0BAD, "R2 reuse");

        // R6 accesses during busy
        @(negedge clk);
        chk(access_err === 1'b0, "R6 no error yet", 32'(access_err), 32'h0);
        wr(3'd2, 16'h0003);
        wr(3'd0, 16'h7777);
        rd(3'd0, 16'h0000, "R6 read during busy");
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(access_err === 1'b1, "R6 error set", 32'(access_err), 32'h1);
        chk(tgt_wdata === 32'hF00D0BAD, "R6 staging unchanged", tgt_wdata, 32'hF00D0BAD);
        wr(3'd3, 16'h2005);
        wr(3'd2, 16'h2006);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(tgt_wstb === 1'b0, "R6 no write strobe from busy trigger", 32'(tgt_wstb), 32'h0);
        end
        ind_rd(16'h2006, 32'h00000000, "R6 target not written");
        ind_rd(16'h0003, 32'hF00D0BAD, "R6 accepted trigger wrote");
        @(negedge clk);
        chk(access_err === 1'b1, "R6 error sticky", 32'(access_err), 32'h1);

        repeat (3) @(posedge clk);
        chk(sb.size() == 0, "scoreboard drained", 32'(sb.size()), 32'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule